// File: doc/BRIEF.md
# Source Chain DMA Tag Engine

This block is the sending half of a processor-to-processor DMA path. Software places a linked series of 128-bit descriptors in local memory and pulses a start strobe with the address of the first one. The engine then works through the series on its own. For each descriptor it fetches all four 32-bit words. It forwards the upper 64 bits into a shared inter-processor FIFO, where the receiving side uses them as its own destination descriptor. It then streams the payload words that the descriptor points to into the same FIFO.

Two words of the descriptor drive the local side. The control word carries a 24-bit payload address and two stop flags. The length word carries a payload count in 32-bit words, which the engine rounds up to whole quadwords. After each descriptor's upper half, the FIFO also receives a short run of pad words. These keep the far side's quadword alignment. Payload reads are paced by the free-space count the FIFO reports, so a full FIFO stalls the engine without losing data. When a descriptor that carries a stop flag has drained its payload, the engine goes idle. In that same cycle it pulses a completion interrupt and presents the number of quadwords it moved.

Top module: `sdma_src_chain`

## Requirements
- R1: After reset the engine is idle: busy, interrupt, read request and FIFO write are all low, and the reported quadword count is 0. A start pulse while idle loads the first descriptor address and raises busy on the next cycle. A start pulse while busy is ignored.
- R2: Each descriptor is fetched as four single-word reads at its address plus 0, 4, 8 and 12 bytes, in that order.
- R3: Descriptor words at byte offsets 8 and 12 are written into the FIFO in that order, followed at once by two pad words of value 0, before any payload of that descriptor.
- R4: The payload is read starting at the byte address held in bits 23:0 of the control word (offset 0), zero-extended. Each following payload word is read 4 bytes higher. Control-word bits 29:24 have no effect.
- R5: The payload count is the length word (offset 4) rounded up to the next multiple of 4. A count of 0 moves no payload. Every payload word read is written into the FIFO in read order.
- R6: When a descriptor has no stop flag, the next descriptor is fetched at the current descriptor address plus 16 bytes.
- R7: The chain ends after the current payload when bit 31 (interrupt request) or bit 30 (end of list) of the control word is set.
- R8: No read is requested and no FIFO word is written while the reported free count is 0. A descriptor fetch does not begin until at least 4 words are free.
- R9: At the end of the chain, busy falls and a single-cycle interrupt pulse rises in the same cycle. The reported count equals the total payload words moved divided by 4, or 1 if that total is 0. The count holds until the next start.
- R10: A read request that is not accepted stays asserted with an unchanged address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| start_addr_i | input | ADDR_W | Byte address of the first descriptor |
| busy_o | output | 1 | Engine is walking a chain |
| irq_o | output | 1 | Completion pulse |
| cycles_o | output | CYC_W | Quadwords moved in the last chain (minimum 1) |
| rd_valid_o | output | 1 | Memory read request |
| rd_addr_o | output | ADDR_W | Byte address of the requested word |
| rd_ready_i | input | 1 | Memory accepts the request; data is valid in this cycle |
| rd_data_i | input | 32 | Read data, valid when request and ready are both high |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | FIFO write data |
| fifo_free_i | input | FREE_W | Free words currently in the FIFO |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 16-bit length words, a 6-bit free count, two pad words and rounding to four words. Around the engine it places a FIFO model whose depth, drain and starting fill can be changed at run time. With a depth of six, a descriptor plus two payload words fills the FIFO exactly. This reaches both the descriptor-fetch gate on free space and the stall on a full FIFO. A pseudo-random ready pattern on the read port makes requests wait, so the bench can see whether a request holds its address while it is stalled.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

   // Descriptor layout the engine depends on.
   localparam int DESC_WORDS    = 4;   // words per descriptor
   localparam int FWD_WORDS     = 2;   // upper half forwarded to the far side
   localparam int PAYLOAD_ABITS = 24;  // payload address field width
   localparam int STOP_IRQ_BIT  = 31;
   localparam int STOP_EOL_BIT  = 30;
   localparam int DESC_BYTES    = DESC_WORDS * 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROOM,   // wait for FIFO room for descriptor half + pad
      ST_DESC,   // fetch descriptor words
      ST_PAD,    // insert pad words
      ST_DATA    // stream payload
   } sdma_state_e;

endpackage

// File: rtl/sdma_tag_latch.sv
module sdma_tag_latch #(
   parameter int CNT_W       = 16,
   parameter int ROUND_WORDS = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cap_ctl_i,
   input  logic                               cap_len_i,
   input  logic [31:0]                        word_i,
   output logic [sdma_pkg::PAYLOAD_ABITS-1:0] data_addr_o,
   output logic                               stop_o,
   output logic [CNT_W:0]                     count_o
);
   import sdma_pkg::*;

   localparam int RB = $clog2(ROUND_WORDS);

   logic [31:0]      ctl_q;
   logic [CNT_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         len_q <= '0;
      end else begin
         if (cap_ctl_i) ctl_q <= word_i;
         if (cap_len_i) len_q <= word_i[CNT_W-1:0];
      end
   end

   assign data_addr_o = ctl_q[PAYLOAD_ABITS-1:0];
   assign stop_o      = ctl_q[STOP_IRQ_BIT] | ctl_q[STOP_EOL_BIT];

   generate
      if (RB == 0) begin : g_no_round
         assign count_o = {1'b0, len_q};
      end else begin : g_round
         logic [CNT_W:0] sum;
         assign sum     = {1'b0, len_q} + (CNT_W+1)'(ROUND_WORDS - 1);
         assign count_o = {sum[CNT_W:RB], {RB{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/sdma_xfer_ctr.sv
module sdma_xfer_ctr #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load_i,
   input  logic                               step_i,
   input  logic [sdma_pkg::PAYLOAD_ABITS-1:0] addr_i,
   input  logic [CNT_W:0]                     count_i,
   output logic [ADDR_W-1:0]                  addr_o,
   output logic                               empty_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W:0]    left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         addr_q <= ADDR_W'(addr_i);
         left_q <= count_i;
      end else if (step_i) begin
         addr_q <= addr_q + ADDR_W'(4);
         left_q <= left_q - (CNT_W+1)'(1);
      end
   end

   assign addr_o  = addr_q;
   assign empty_o = (left_q == '0);

endmodule

// File: rtl/sdma_cycle_acc.sv
module sdma_cycle_acc #(
   parameter int CYC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             word_i,
   input  logic             report_i,
   output logic [CYC_W-1:0] cycles_o
);
   logic [CYC_W+1:0] words_q;
   logic [CYC_W-1:0] qw;
   logic [CYC_W-1:0] cycles_q;

   assign qw = words_q[CYC_W+1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q  <= '0;
         cycles_q <= '0;
      end else begin
         if (clr_i)       words_q <= '0;
         else if (word_i) words_q <= words_q + (CYC_W+2)'(1);
         if (clr_i)         cycles_q <= '0;
         else if (report_i) cycles_q <= (qw == '0) ? CYC_W'(1) : qw;
      end
   end

   assign cycles_o = cycles_q;

endmodule

// File: rtl/sdma_src_chain.sv
module sdma_src_chain #(
   parameter int          ADDR_W      = 32,
   parameter int          CNT_W       = 16,
   parameter int          FREE_W      = 6,
   parameter int          CYC_W       = 16,
   parameter int          GAP_WORDS   = 2,
   parameter int          ROUND_WORDS = 4,
   parameter logic [31:0] PAD_WORD    = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic              busy_o,
   output logic              irq_o,
   output logic [CYC_W-1:0]  cycles_o,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ready_i,
   input  logic [31:0]       rd_data_i,
   output logic              fifo_wr_o,
   output logic [31:0]       fifo_wdata_o,
   input  logic [FREE_W-1:0] fifo_free_i
);
   import sdma_pkg::*;

   localparam int ROOM  = FWD_WORDS + GAP_WORDS;
   localparam int GAP_CW = $clog2(GAP_WORDS) + 1;

   generate
      if (ADDR_W < PAYLOAD_ABITS) begin : g_chk_addr
         $error("ADDR_W must cover the payload address field");
      end
      if (CNT_W < 3 || CNT_W > 31) begin : g_chk_cnt
         $error("CNT_W out of range");
      end
      if (GAP_WORDS < 1) begin : g_chk_gap
         $error("GAP_WORDS must be at least 1");
      end
      if ((1 << $clog2(ROUND_WORDS)) != ROUND_WORDS) begin : g_chk_round
         $error("ROUND_WORDS must be a power of two");
      end
      if (ROOM >= (1 << FREE_W)) begin : g_chk_free
         $error("FREE_W too narrow for descriptor room");
      end
   endgenerate

   sdma_state_e         state_q;
   logic [ADDR_W-1:0]   desc_addr_q;
   logic [1:0]          widx_q;
   logic [GAP_CW-1:0]   gap_q;
   logic                irq_q;

   logic                rd_beat;
   logic                room_ok;
   logic                pad_last;
   logic                finish;
   logic                ctr_load;
   logic                ctr_step;
   logic                ctr_empty;
   logic [ADDR_W-1:0]   pay_addr;
   logic [PAYLOAD_ABITS-1:0] tag_daddr;
   logic                tag_stop;
   logic [CNT_W:0]      tag_count;

   assign rd_beat  = rd_valid_o & rd_ready_i;
   assign room_ok  = fifo_free_i >= FREE_W'(ROOM);
   assign pad_last = (state_q == ST_PAD) && (gap_q == GAP_CW'(GAP_WORDS - 1));
   assign finish   = (state_q == ST_DATA) && ctr_empty && tag_stop;
   assign ctr_load = pad_last;
   assign ctr_step = (state_q == ST_DATA) && rd_beat;

   // descriptor word capture
   sdma_tag_latch #(
      .CNT_W      (CNT_W),
      .ROUND_WORDS(ROUND_WORDS)
   ) u_tag (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_ctl_i  ((state_q == ST_DESC) && rd_beat && (widx_q == 2'd0)),
      .cap_len_i  ((state_q == ST_DESC) && rd_beat && (widx_q == 2'd1)),
      .word_i     (rd_data_i),
      .data_addr_o(tag_daddr),
      .stop_o     (tag_stop),
      .count_o    (tag_count)
   );

   // payload address and remaining count
   sdma_xfer_ctr #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ctr_load),
      .step_i (ctr_step),
      .addr_i (tag_daddr),
      .count_i(tag_count),
      .addr_o (pay_addr),
      .empty_o(ctr_empty)
   );

   // quadword accounting for the completion report
   sdma_cycle_acc #(
      .CYC_W   (CYC_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   ((state_q == ST_IDLE) && start_i),
      .word_i  (ctr_step),
      .report_i(finish),
      .cycles_o(cycles_o)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         desc_addr_q <= '0;
         widx_q      <= '0;
         gap_q       <= '0;
         irq_q       <= 1'b0;
      end else begin
         irq_q <= finish;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  desc_addr_q <= start_addr_i;
                  state_q     <= ST_ROOM;
               end
            end
            ST_ROOM: begin
               if (room_ok) begin
                  widx_q  <= '0;
                  state_q <= ST_DESC;
               end
            end
            ST_DESC: begin
               if (rd_beat) begin
                  widx_q <= widx_q + 2'd1;
                  if (widx_q == 2'd3) begin
                     gap_q   <= '0;
                     state_q <= ST_PAD;
                  end
               end
            end
            ST_PAD: begin
               gap_q <= gap_q + GAP_CW'(1);
               if (pad_last) begin
                  desc_addr_q <= desc_addr_q + ADDR_W'(DESC_BYTES);
                  state_q     <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (ctr_empty) begin
                  state_q <= tag_stop ? ST_IDLE : ST_ROOM;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // read port and FIFO write port
   always_comb begin
      rd_valid_o   = 1'b0;
      rd_addr_o    = desc_addr_q + ADDR_W'({widx_q, 2'b00});
      fifo_wr_o    = 1'b0;
      fifo_wdata_o = rd_data_i;
      unique case (state_q)
         ST_DESC: begin
            rd_valid_o = 1'b1;
            fifo_wr_o  = rd_beat && widx_q[1];
         end
         ST_PAD: begin
            fifo_wr_o    = 1'b1;
            fifo_wdata_o = PAD_WORD;
         end
         ST_DATA: begin
            rd_addr_o  = pay_addr;
            rd_valid_o = !ctr_empty && (fifo_free_i != '0);
            fifo_wr_o  = rd_beat;
         end
         default: ;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);
   assign irq_o  = irq_q;

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
   parameter int ADDR_W = 32,
   parameter int CYC_W  = 16,
   parameter int FREE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              irq_o,
   input logic [CYC_W-1:0]  cycles_o,
   input logic              rd_valid_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              rd_ready_i,
   input logic              fifo_wr_o,
   input logic [FREE_W-1:0] fifo_free_i
);
   // R1: an idle engine issues nothing
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!rd_valid_o && !fifo_wr_o));

   // R1: busy only drops together with completion
   p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || irq_o));

   // R8: no read while the FIFO has no room
   p_no_read_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> (fifo_free_i != '0));

   // R8: no write into a full FIFO
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_o |-> (fifo_free_i != '0));

   // R9: completion coincides with idle
   p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !busy_o);

   // R9: completion is a single-cycle pulse
   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R9: reported quadword count never zero on completion
   p_cycles_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cycles_o != '0));

   // R10: stalled request holds
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

endmodule

bind sdma_src_chain sdma_checker #(
   .ADDR_W(ADDR_W),
   .CYC_W (CYC_W),
   .FREE_W(FREE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .irq_o      (irq_o),
   .cycles_o   (cycles_o),
   .rd_valid_o (rd_valid_o),
   .rd_addr_o  (rd_addr_o),
   .rd_ready_i (rd_ready_i),
   .fifo_wr_o  (fifo_wr_o),
   .fifo_free_i(fifo_free_i)
);

// File: tb/sdma_src_chain_bench.sv
`timescale 1ns/100ps
module sdma_src_chain_bench;

   localparam int ADDR_W = 32;
   localparam int CYC_W  = 16;
   localparam int FREE_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic              busy, irq, rd_valid, fifo_wr;
   logic [CYC_W-1:0]  cycles;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_ready = 1'b1;
   logic [31:0]       rd_data, fifo_wdata;
   logic [FREE_W-1:0] fifo_free;

   // bench state
   logic [31:0] mem [0:1023];
   logic [31:0] got_data[$];
   logic [31:0] got_addr[$];
   logic [31:0] exp_data[$];
   logic [31:0] exp_addr[$];
   int          exp_words;
   int          fill = 0;
   int          depth = 32;
   bit          drain = 1'b1;
   bit          set_req = 1'b0;
   int          set_val = 0;
   bit          stall_mode = 1'b0;
   logic [7:0]  lfsr = 8'h5a;
   int          irq_cnt = 0;
   int          stall_seen = 0;
   int          checks = 0;
   int          errors = 0;
   bit          ended = 1'b0;

   always #2.5 clk = ~clk;

   sdma_src_chain u_sdma_src_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .start_addr_i(start_addr),
      .busy_o      (busy),
      .irq_o       (irq),
      .cycles_o    (cycles),
      .rd_valid_o  (rd_valid),
      .rd_addr_o   (rd_addr),
      .rd_ready_i  (rd_ready),
      .rd_data_i   (rd_data),
      .fifo_wr_o   (fifo_wr),
      .fifo_wdata_o(fifo_wdata),
      .fifo_free_i (fifo_free)
   );

   assign rd_data   = mem[rd_addr[11:2]];
   assign fifo_free = FREE_W'(depth - fill);

   // memory, FIFO and ready models
   always @(posedge clk) begin
      if (fifo_wr) got_data.push_back(fifo_wdata);
      if (rd_valid && rd_ready) got_addr.push_back(rd_addr);
      if (rd_valid && !rd_ready) stall_seen++;
      if (irq) irq_cnt++;
      if (set_req) fill <= set_val;
      else fill <= fill + (fifo_wr ? 1 : 0) - ((drain && fill > 0) ? 1 : 0);
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_ready <= stall_mode ? (lfsr[0] | lfsr[4]) : 1'b1;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3);
      mem[a/4]   = w0;
      mem[a/4+1] = w1;
      mem[a/4+2] = w2;
      mem[a/4+3] = w3;
   endtask

   // expected traffic for a chain, built from the requirement text
   task automatic build_expect(input int first);
      int t;
      exp_data.delete();
      exp_addr.delete();
      exp_words = 0;
      t = first;
      for (int n = 0; n < 16; n++) begin
         logic [31:0] w0;
         int cnt, da;
         w0 = mem[t/4];
         for (int k = 0; k < 4; k++) exp_addr.push_back(32'(t + 4*k));   // R2
         exp_data.push_back(mem[t/4+2]);                                  // R3
         exp_data.push_back(mem[t/4+3]);
         exp_data.push_back(32'h0);
         exp_data.push_back(32'h0);
         cnt = (int'(mem[t/4+1][15:0]) + 3) / 4 * 4;                      // R5
         da  = int'(w0[23:0]);                                            // R4
         for (int k = 0; k < cnt; k++) begin
            exp_addr.push_back(32'(da + 4*k));
            exp_data.push_back(mem[(da/4 + k) % 1024]);
         end
         exp_words += cnt;
         if (w0[31] || w0[30]) break;                                     // R7
         t += 16;                                                         // R6
      end
   endtask

   task automatic compare_logs(input string req);
      bit same;
      check(got_addr.size() == exp_addr.size(), {req, " read count"},
            32'(got_addr.size()), 32'(exp_addr.size()));
      same = (got_addr.size() == exp_addr.size());
      for (int i = 0; same && i < exp_addr.size(); i++)
         if (got_addr[i] !== exp_addr[i]) begin
            check(1'b0, {req, " read address"}, got_addr[i], exp_addr[i]);
            same = 1'b0;
         end
      check(got_data.size() == exp_data.size(), {req, " fifo count"},
            32'(got_data.size()), 32'(exp_data.size()));
      same = (got_data.size() == exp_data.size());
      for (int i = 0; same && i < exp_data.size(); i++)
         if (got_data[i] !== exp_data[i]) begin
            check(1'b0, {req, " fifo word"}, got_data[i], exp_data[i]);
            same = 1'b0;
         end
   endtask

   task automatic launch(input int a);
      @(negedge clk);
      got_data.delete();
      got_addr.delete();
      start      = 1'b1;
      start_addr = 32'(a);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int base;
      bit hit;
      base = irq_cnt;
      hit  = 1'b0;
      for (int i = 0; i < 4000 && !hit; i++) begin
         @(negedge clk);
         if (irq) hit = 1'b1;
      end
      check(hit, {req, " completion"}, 32'(hit), 32'd1);
      if (hit) begin
         check(!busy, "R9 busy low with irq", 32'(busy), 32'd0);
         @(negedge clk);
         check(!irq, "R9 irq single pulse", 32'(irq), 32'd0);
         check(irq_cnt == base + 1, "R9 one irq", 32'(irq_cnt - base), 32'd1);
      end
   endtask

   task automatic t_reset;
      check(!busy, "R1 reset busy", 32'(busy), 0);
      check(!irq, "R1 reset irq", 32'(irq), 0);
      check(!rd_valid && !fifo_wr, "R1 reset ports quiet", 32'({rd_valid, fifo_wr}), 0);
      check(cycles == 0, "R1 reset count", 32'(cycles), 0);
   endtask

   task automatic t_single;
      set_desc(32'h100, 32'h4000_0400, 32'd6, 32'hD2D2_0001, 32'hD3D3_0001);
      build_expect(32'h100);
      launch(32'h100);
      check(busy, "R1 busy after start", 32'(busy), 1);
      wait_done("R3");
      compare_logs("R2 R3 R4 R5 single");
      check(cycles == 16'd2, "R9 quadwords single", 32'(cycles), 32'd2);
   endtask

   task automatic t_chain;
      set_desc(32'h200, 32'h0000_0500, 32'd5, 32'hAAAA_0002, 32'hBBBB_0002);
      set_desc(32'h210, 32'h8000_0580, 32'd3, 32'hAAAA_0003, 32'hBBBB_0003);
      build_expect(32'h200);
      launch(32'h200);
      wait_done("R7");
      compare_logs("R6 R7 chain");
      check(cycles == 16'd3, "R9 quadwords chain", 32'(cycles), 32'd3);
   endtask

   task automatic t_zero;
      set_desc(32'h300, 32'h4000_0000, 32'd0, 32'h1234_5678, 32'h9ABC_DEF0);
      build_expect(32'h300);
      launch(32'h300);
      wait_done("R5");
      compare_logs("R5 zero count");
      check(cycles == 16'd1, "R9 zero forced to one", 32'(cycles), 32'd1);
   endtask

   task automatic t_mask;
      set_desc(32'h340, 32'h4F00_0640, 32'd4, 32'h0F0F_0004, 32'hF0F0_0004);
      build_expect(32'h340);
      launch(32'h340);
      wait_done("R4");
      compare_logs("R4 upper control bits ignored");
      check(got_addr.size() > 4 && got_addr[4] == 32'h640, "R4 payload base",
            (got_addr.size() > 4) ? got_addr[4] : 32'hFFFF_FFFF, 32'h640);
      check(cycles == 16'd1, "R5 exact multiple", 32'(cycles), 32'd1);
   endtask

   task automatic t_full;
      set_desc(32'h380, 32'h4000_0700, 32'd8, 32'h5555_0005, 32'h6666_0005);
      build_expect(32'h380);
      depth = 6;
      drain = 1'b0;
      @(negedge clk);
      set_req = 1'b1; set_val = 3;
      @(negedge clk);
      set_req = 1'b0;
      launch(32'h380);
      repeat (20) @(negedge clk);
      check(got_addr.size() == 0, "R8 no fetch below room", 32'(got_addr.size()), 0);
      check(busy, "R8 busy while waiting", 32'(busy), 1);
      set_req = 1'b1; set_val = 0;
      @(negedge clk);
      set_req = 1'b0;
      repeat (30) @(negedge clk);
      check(got_addr.size() == 6, "R8 reads stop when full", 32'(got_addr.size()), 32'd6);
      check(!rd_valid, "R8 no request when full", 32'(rd_valid), 0);
      check(busy, "R8 busy while full", 32'(busy), 1);
      drain = 1'b1;
      wait_done("R8");
      compare_logs("R8 paced transfer");
      depth = 32;
   endtask

   task automatic t_stall;
      stall_mode = 1'b1;
      stall_seen = 0;
      build_expect(32'h200);
      launch(32'h200);
      wait_done("R10");
      compare_logs("R10 stalled chain");
      check(stall_seen > 0, "R10 stalls exercised", 32'(stall_seen), 32'd1);
      stall_mode = 1'b0;
   endtask

   task automatic t_busy_start;
      build_expect(32'h100);
      launch(32'h100);
      repeat (3) @(negedge clk);
      start = 1'b1; start_addr = 32'h300;
      @(negedge clk);
      start = 1'b0;
      wait_done("R1");
      compare_logs("R1 start while busy ignored");
      build_expect(32'h300);
      launch(32'h300);
      wait_done("R1");
      compare_logs("R1 restart loads address");
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_chain();
      t_zero();
      t_mask();
      t_full();
      t_stall();
      t_busy_start();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule